// File: doc/BRIEF.md
# Random Memory Traffic Tester

This block stresses a memory hierarchy with a stream of pseudo-random single-byte reads and writes. It also verifies every read it gets back. It keeps a private shadow of what each byte it has written should hold. Each read carries the expected byte taken from that shadow when the read was issued. When the response arrives, the returned byte is compared with the expected one.

Several instances can share one memory system as false-sharing agents. Each instance always touches byte `TESTER_ID` inside every block of `BLK_BYTES` bytes, so the instances share cache blocks without sharing bytes. Requests go to one of three regions: two cacheable regions, and an uncacheable region whose requests carry a flag.

The block never has two requests to the same byte in flight. It holds a refused request until the port takes it. It raises a deadlock flag when responses stop arriving. It counts completed reads and pulses a progress marker at fixed intervals. It stops generating traffic once it has seen enough reads.

Top module: `mem_traffic_tester`

## Requirements
- R1: Each cycle, a draw taken as a 16-bit pseudo-random value modulo 100 picks a read when it is below `RD_PCT`, and a write otherwise (`req_write_o`=1 means write). With 0 < `RD_PCT` < 100, both kinds appear.
- R2: Every request is one byte. Its address is a region base plus an offset below `MEM_BYTES`. The low log2(`BLK_BYTES`) bits of the offset equal `TESTER_ID`.
- R3: `req_uncached_o` is 1 exactly when the region base is 0x800000. Cacheable requests use base 0x100000 or base 0x400000, so address bits [23:20] are 1, 4 or 8.
- R4: A new request is never issued to an address whose earlier request has not yet received its response. A conflicting candidate is dropped for that cycle.
- R5: A request that is presented while `req_ready_i` is 0 stays presented in the next cycle with the same address, kind, flag and data. Nothing new is generated while a request is held.
- R6: The shadow resets to all zero and takes a write's data when the write is issued. A read that returns the shadow's byte raises no error.
- R7: A read response that differs from its expected byte sets `mismatch_o`, which stays set until reset. The first offending address, the returned byte and the expected byte appear on `mis_addr_o`, `mis_got_o` and `mis_exp_o`, and later mismatches do not change them.
- R8: A counter of cycles without any response is cleared by every response. When it reaches `DEADLOCK_CYCLES`, `deadlock_o` is set and stays set until reset.
- R9: `progress_o` pulses for one cycle each time the count of completed reads reaches a multiple of `PROG_INTERVAL`.
- R10: `done_o` is set in the cycle after the completed read count reaches `MAX_LOADS`, and stays set. No request is generated after that point.
- R11: At most `SLOTS` requests are in flight at once. Generation stalls while all slots are taken.
- R12: While `rst_ni` is low, `req_valid_o`, `mismatch_o`, `deadlock_o`, `progress_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_o | output | 1 | Request presented |
| req_ready_i | input | 1 | Port accepts the request this cycle; 0 means refused and retried |
| req_write_o | output | 1 | 1 = write, 0 = read |
| req_uncached_o | output | 1 | Request targets the uncacheable region |
| req_addr_o | output | 24 | Byte address |
| req_data_o | output | 8 | Write data |
| rsp_valid_i | input | 1 | Response present |
| rsp_write_i | input | 1 | Response belongs to a write |
| rsp_addr_i | input | 24 | Address of the completed request |
| rsp_data_i | input | 8 | Returned read byte |
| mismatch_o | output | 1 | Sticky read data error |
| mis_addr_o | output | 24 | Address of the first error |
| mis_got_o | output | 8 | Byte returned at the first error |
| mis_exp_o | output | 8 | Byte expected at the first error |
| deadlock_o | output | 1 | Sticky no-response flag |
| progress_o | output | 1 | One-cycle progress pulse |
| done_o | output | 1 | Read target reached |

## Verification
A corrupted shadow entry or expected-value slot shows up as a false `mismatch_o`. It appears in the cycle after the first read of the affected byte returns, which is usually within tens of cycles of traffic. A stale or lost entry in the in-flight table shows up at the request port in one of two ways. Either a second request to a busy address appears, which the bench catches at acceptance, or generation freezes with fewer than `SLOTS` requests outstanding. Miscounting is visible through the number of `progress_o` pulses and through the exact read count at which `done_o` rises. A wrong idle counter moves the rise of `deadlock_o` away from `DEADLOCK_CYCLES` edges after the last response.

// File: rtl/mtt_pkg.sv
package mtt_pkg;
  localparam int unsigned ADDR_W     = 24;
  localparam int unsigned REGION_CNT = 3;

  localparam logic [ADDR_W-1:0] BASE_A  = 24'h10_0000;
  localparam logic [ADDR_W-1:0] BASE_B  = 24'h40_0000;
  localparam logic [ADDR_W-1:0] BASE_UC = 24'h80_0000;

  typedef enum logic [1:0] {
    REG_A  = 2'd0,
    REG_B  = 2'd1,
    REG_UC = 2'd2
  } region_e;

  typedef struct packed {
    logic              write;
    logic              uncached;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        data;
  } mtt_req_t;
endpackage

// File: rtl/mtt_lfsr.sv
module mtt_lfsr #(
  parameter logic [31:0] SEED = 32'h1,
  parameter logic [31:0] TAPS = 32'h8020_0003
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic [31:0] state_o
);
  localparam logic [31:0] INIT = (SEED == 32'h0) ? 32'h1 : SEED;

  logic [31:0] state_q;

  // Galois form, advances every cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         state_q <= INIT;
    else if (state_q[0]) state_q <= (state_q >> 1) ^ TAPS;
    else                 state_q <= state_q >> 1;
  end

  assign state_o = state_q;
endmodule

// File: rtl/mtt_shadow.sv
module mtt_shadow
  import mtt_pkg::*;
#(
  parameter  int unsigned MEM_BYTES = 256,
  localparam int unsigned OFF_W     = $clog2(MEM_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  region_e          region_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [7:0]       rd_data_o,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i
);
  logic [REGION_CNT-1:0][7:0] rd_bank;

  for (genvar g = 0; g < REGION_CNT; g++) begin : g_bank
    logic [7:0] mem_q [MEM_BYTES];
    logic       sel;

    assign sel = (32'(region_i) == g);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= '0;
      end else if (wr_en_i && sel) begin
        mem_q[off_i] <= wr_data_i;
      end
    end

    assign rd_bank[g] = mem_q[off_i];
  end

  always_comb begin
    case (region_i)
      REG_A:   rd_data_o = rd_bank[0];
      REG_B:   rd_data_o = rd_bank[1];
      default: rd_data_o = rd_bank[2];
    endcase
  end
endmodule

// File: rtl/mtt_inflight.sv
module mtt_inflight
  import mtt_pkg::*;
#(
  parameter  int unsigned SLOTS = 8,
  localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] probe_addr_i,
  output logic              hit_o,
  output logic              full_o,
  input  logic              alloc_i,
  input  logic              alloc_read_i,
  input  logic [7:0]        alloc_exp_i,
  input  logic              rel_i,
  input  logic [ADDR_W-1:0] rel_addr_i,
  output logic              rel_hit_o,
  output logic              rel_read_o,
  output logic [7:0]        rel_exp_o
);
  logic [SLOTS-1:0]             vld_q;
  logic [SLOTS-1:0]             rd_q;
  logic [SLOTS-1:0][ADDR_W-1:0] addr_q;
  logic [SLOTS-1:0][7:0]        exp_q;
  logic [SLOTS-1:0]             probe_m, rel_m;
  logic [IDX_W-1:0]             free_idx;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign probe_m[s] = vld_q[s] && (addr_q[s] == probe_addr_i);
    assign rel_m[s]   = vld_q[s] && (addr_q[s] == rel_addr_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[s]  <= 1'b0;
        rd_q[s]   <= 1'b0;
        addr_q[s] <= '0;
        exp_q[s]  <= '0;
      end else if (alloc_i && (free_idx == IDX_W'(s)) && !vld_q[s]) begin
        vld_q[s]  <= 1'b1;
        rd_q[s]   <= alloc_read_i;
        addr_q[s] <= probe_addr_i;
        exp_q[s]  <= alloc_exp_i;
      end else if (rel_i && rel_m[s]) begin
        vld_q[s] <= 1'b0;
      end
    end
  end

  // lowest free slot
  always_comb begin
    free_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!vld_q[i]) free_idx = IDX_W'(i);
    end
  end

  always_comb begin
    rel_read_o = 1'b0;
    rel_exp_o  = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (rel_m[i]) begin
        rel_read_o = rd_q[i];
        rel_exp_o  = exp_q[i];
      end
    end
  end

  assign hit_o     = |probe_m;
  assign full_o    = &vld_q;
  assign rel_hit_o = |rel_m;
endmodule

// File: rtl/mtt_rsp_check.sv
module mtt_rsp_check
  import mtt_pkg::*;
#(
  parameter int unsigned PROG_INTERVAL   = 16,
  parameter int unsigned MAX_LOADS       = 1000,
  parameter int unsigned DEADLOCK_CYCLES = 500000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rsp_valid_i,
  input  logic              rsp_write_i,
  input  logic [ADDR_W-1:0] rsp_addr_i,
  input  logic [7:0]        rsp_data_i,
  input  logic              rel_hit_i,
  input  logic              rel_read_i,
  input  logic [7:0]        rel_exp_i,
  output logic              stop_o,
  output logic              mismatch_o,
  output logic [ADDR_W-1:0] mis_addr_o,
  output logic [7:0]        mis_got_o,
  output logic [7:0]        mis_exp_o,
  output logic              deadlock_o,
  output logic              progress_o,
  output logic              done_o
);
  localparam int unsigned IDLE_W = $clog2(DEADLOCK_CYCLES + 1);

  logic              rd_done;
  logic [31:0]       rd_cnt_q, rd_cnt_d, next_prog_q;
  logic [IDLE_W-1:0] idle_q;
  logic              done_set;

  assign rd_done  = rsp_valid_i && !rsp_write_i && rel_hit_i && rel_read_i;
  assign rd_cnt_d = rd_cnt_q + 32'(rd_done);
  assign done_set = rd_cnt_d >= MAX_LOADS;
  assign stop_o   = done_o || done_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_cnt_q    <= '0;
      next_prog_q <= PROG_INTERVAL;
      progress_o  <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      rd_cnt_q   <= rd_cnt_d;
      progress_o <= 1'b0;
      if (rd_done && (rd_cnt_d == next_prog_q)) begin
        progress_o  <= 1'b1;
        next_prog_q <= next_prog_q + PROG_INTERVAL;
      end
      if (done_set) done_o <= 1'b1;
    end
  end

  // first mismatch wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mismatch_o <= 1'b0;
      mis_addr_o <= '0;
      mis_got_o  <= '0;
      mis_exp_o  <= '0;
    end else if (rd_done && (rsp_data_i != rel_exp_i) && !mismatch_o) begin
      mismatch_o <= 1'b1;
      mis_addr_o <= rsp_addr_i;
      mis_got_o  <= rsp_data_i;
      mis_exp_o  <= rel_exp_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q     <= '0;
      deadlock_o <= 1'b0;
    end else begin
      if (rsp_valid_i)                             idle_q <= '0;
      else if (idle_q != IDLE_W'(DEADLOCK_CYCLES)) idle_q <= idle_q + 1'b1;
      if (!rsp_valid_i && (idle_q == IDLE_W'(DEADLOCK_CYCLES))) deadlock_o <= 1'b1;
    end
  end
endmodule

// File: rtl/mem_traffic_tester.sv
module mem_traffic_tester
  import mtt_pkg::*;
#(
  parameter int unsigned TESTER_ID       = 0,
  parameter int unsigned BLK_BYTES       = 16,
  parameter int unsigned MEM_BYTES       = 256,
  parameter int unsigned RD_PCT          = 50,
  parameter int unsigned UC_PCT          = 20,
  parameter int unsigned SLOTS           = 8,
  parameter int unsigned PROG_INTERVAL   = 16,
  parameter int unsigned MAX_LOADS       = 1000,
  parameter int unsigned DEADLOCK_CYCLES = 500000,
  parameter logic [31:0] SEED            = 32'h1ace_b00c
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_write_o,
  output logic              req_uncached_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [7:0]        req_data_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_write_i,
  input  logic [ADDR_W-1:0] rsp_addr_i,
  input  logic [7:0]        rsp_data_i,
  output logic              mismatch_o,
  output logic [ADDR_W-1:0] mis_addr_o,
  output logic [7:0]        mis_got_o,
  output logic [7:0]        mis_exp_o,
  output logic              deadlock_o,
  output logic              progress_o,
  output logic              done_o
);
  localparam int unsigned     OFF_W    = $clog2(MEM_BYTES);
  localparam int unsigned     N_DRAW   = 2;
  localparam logic [OFF_W-1:0] BLK_MASK = OFF_W'(BLK_BYTES - 1);
  localparam logic [OFF_W-1:0] ID_OFF   = OFF_W'(TESTER_ID);

  logic [N_DRAW-1:0][31:0] draw;

  for (genvar k = 0; k < N_DRAW; k++) begin : g_rng
    mtt_lfsr #(.SEED(SEED ^ (32'(k) * 32'h9e37_79b9))) u_lfsr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .state_o (draw[k])
    );
  end

  // candidate request
  logic [6:0]        cmd_pct, uc_pct;
  logic [OFF_W-1:0]  off_rnd, cand_off;
  logic              cand_uc, cand_write;
  region_e           cand_region;
  logic [ADDR_W-1:0] cand_base, cand_addr;
  logic [7:0]        cand_data;

  assign cmd_pct    = 7'({16'b0, draw[0][15:0]} % 32'd100);
  assign uc_pct     = 7'({16'b0, draw[1][15:0]} % 32'd100);
  assign off_rnd    = OFF_W'({16'b0, draw[0][31:16]} % MEM_BYTES);
  assign cand_off   = (off_rnd & ~BLK_MASK) | ID_OFF;
  assign cand_uc    = 32'(uc_pct) < UC_PCT;
  assign cand_write = !(32'(cmd_pct) < RD_PCT);
  assign cand_data  = draw[1][31:24] ^ {draw[1][23:17], 1'b0};

  always_comb begin
    if (cand_uc)          cand_region = REG_UC;
    else if (draw[1][16]) cand_region = REG_A;
    else                  cand_region = REG_B;
    case (cand_region)
      REG_A:   cand_base = BASE_A;
      REG_B:   cand_base = BASE_B;
      default: cand_base = BASE_UC;
    endcase
  end

  assign cand_addr = cand_base + ADDR_W'(cand_off);

  // issue control
  logic     tbl_hit, tbl_full, stop;
  logic     issue, load_ok;
  logic     req_vld_q;
  mtt_req_t req_q;
  logic [7:0] shadow_byte;
  logic       rel_hit, rel_read;
  logic [7:0] rel_exp;

  assign load_ok = !req_vld_q || req_ready_i;
  assign issue   = load_ok && !tbl_hit && !tbl_full && !stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_vld_q <= 1'b0;
      req_q     <= '0;
    end else if (issue) begin
      req_vld_q      <= 1'b1;
      req_q.write    <= cand_write;
      req_q.uncached <= cand_uc;
      req_q.addr     <= cand_addr;
      req_q.data     <= cand_write ? cand_data : 8'h00;
    end else if (req_ready_i) begin
      req_vld_q <= 1'b0;
    end
  end

  assign req_valid_o    = req_vld_q;
  assign req_write_o    = req_q.write;
  assign req_uncached_o = req_q.uncached;
  assign req_addr_o     = req_q.addr;
  assign req_data_o     = req_q.data;

  mtt_shadow #(.MEM_BYTES(MEM_BYTES)) u_shadow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .region_i  (cand_region),
    .off_i     (cand_off),
    .rd_data_o (shadow_byte),
    .wr_en_i   (issue && cand_write),
    .wr_data_i (cand_data)
  );

  mtt_inflight #(.SLOTS(SLOTS)) u_inflight (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .probe_addr_i (cand_addr),
    .hit_o        (tbl_hit),
    .full_o       (tbl_full),
    .alloc_i      (issue),
    .alloc_read_i (!cand_write),
    .alloc_exp_i  (shadow_byte),
    .rel_i        (rsp_valid_i),
    .rel_addr_i   (rsp_addr_i),
    .rel_hit_o    (rel_hit),
    .rel_read_o   (rel_read),
    .rel_exp_o    (rel_exp)
  );

  mtt_rsp_check #(
    .PROG_INTERVAL   (PROG_INTERVAL),
    .MAX_LOADS       (MAX_LOADS),
    .DEADLOCK_CYCLES (DEADLOCK_CYCLES)
  ) u_rsp_check (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rsp_valid_i (rsp_valid_i),
    .rsp_write_i (rsp_write_i),
    .rsp_addr_i  (rsp_addr_i),
    .rsp_data_i  (rsp_data_i),
    .rel_hit_i   (rel_hit),
    .rel_read_i  (rel_read),
    .rel_exp_i   (rel_exp),
    .stop_o      (stop),
    .mismatch_o  (mismatch_o),
    .mis_addr_o  (mis_addr_o),
    .mis_got_o   (mis_got_o),
    .mis_exp_o   (mis_exp_o),
    .deadlock_o  (deadlock_o),
    .progress_o  (progress_o),
    .done_o      (done_o)
  );
endmodule

// File: rtl/mtt_checker.sv
module mtt_checker
  import mtt_pkg::*;
#(
  parameter int unsigned TESTER_ID = 0,
  parameter int unsigned BLK_BYTES = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic              req_write_o,
  input logic              req_uncached_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [7:0]        req_data_o,
  input logic              mismatch_o,
  input logic [ADDR_W-1:0] mis_addr_o,
  input logic [7:0]        mis_got_o,
  input logic [7:0]        mis_exp_o,
  input logic              deadlock_o,
  input logic              done_o
);
  localparam int unsigned BLK_W = $clog2(BLK_BYTES);

  // R5
  retry_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) &&
      $stable(req_write_o) && $stable(req_uncached_o) && $stable(req_data_o));

  // R2
  byte_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> req_addr_o[BLK_W-1:0] == BLK_W'(TESTER_ID));

  // R3
  region_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_uncached_o == (req_addr_o[23:20] == 4'h8)) &&
      (req_addr_o[23:20] == 4'h1 || req_addr_o[23:20] == 4'h4 || req_addr_o[23:20] == 4'h8));

  // R7
  mismatch_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch_o |=> mismatch_o && $stable(mis_addr_o) && $stable(mis_got_o) && $stable(mis_exp_o));

  // R8
  deadlock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deadlock_o |=> deadlock_o);

  // R10
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  // R10
  no_issue_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !req_valid_o |=> !req_valid_o);
endmodule

bind mem_traffic_tester mtt_checker #(
  .TESTER_ID (TESTER_ID),
  .BLK_BYTES (BLK_BYTES)
) u_mtt_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_o    (req_valid_o),
  .req_ready_i    (req_ready_i),
  .req_write_o    (req_write_o),
  .req_uncached_o (req_uncached_o),
  .req_addr_o     (req_addr_o),
  .req_data_o     (req_data_o),
  .mismatch_o     (mismatch_o),
  .mis_addr_o     (mis_addr_o),
  .mis_got_o      (mis_got_o),
  .mis_exp_o      (mis_exp_o),
  .deadlock_o     (deadlock_o),
  .done_o         (done_o)
);

// File: tb/mem_traffic_tester_test.sv
`timescale 1ns/1ps
module mem_traffic_tester_test;
  localparam int ID    = 5;
  localparam int BLK   = 16;
  localparam int MEM   = 256;
  localparam int SLOTS = 8;
  localparam int PROG  = 8;
  localparam int MAXL  = 120;
  localparam int DL    = 300;
  localparam int LAT   = 3;
  localparam int QN    = 64;
  localparam int WD_CYC = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_o, req_ready_i, req_write_o, req_uncached_o;
  logic [23:0] req_addr_o;
  logic [7:0]  req_data_o;
  logic        rsp_valid_i, rsp_write_i;
  logic [23:0] rsp_addr_i;
  logic [7:0]  rsp_data_i;
  logic        mismatch_o, deadlock_o, progress_o, done_o;
  logic [23:0] mis_addr_o;
  logic [7:0]  mis_got_o, mis_exp_o;

  always #2 clk_i = ~clk_i;

  mem_traffic_tester #(
    .TESTER_ID(ID), .BLK_BYTES(BLK), .MEM_BYTES(MEM), .RD_PCT(50), .UC_PCT(30),
    .SLOTS(SLOTS), .PROG_INTERVAL(PROG), .MAX_LOADS(MAXL), .DEADLOCK_CYCLES(DL)
  ) uut (
    .clk_i, .rst_ni, .req_valid_o, .req_ready_i, .req_write_o, .req_uncached_o,
    .req_addr_o, .req_data_o, .rsp_valid_i, .rsp_write_i, .rsp_addr_i, .rsp_data_i,
    .mismatch_o, .mis_addr_o, .mis_got_o, .mis_exp_o, .deadlock_o, .progress_o, .done_o
  );

  int total = 0, bad = 0;
  bit finished = 0;
  int cyc;
  int ready_mode;
  bit resp_en;
  logic [7:0] mem_m [3*MEM];
  bit   busy [3*MEM];
  logic [23:0] q_addr [QN];
  bit          q_wr [QN];
  int          q_due [QN];
  int head, tail;
  int form_err, region_err, dup_err, hold_err, refusals, max_out;
  int rd_acc, wr_acc, rd_resp, prog_cnt, after_done, done_allow, rd_at_done;
  bit done_seen, prev_refused;
  bit seen_rg [3];
  logic [23:0] p_addr; logic p_wr, p_uc; logic [7:0] p_data;
  bit corrupt_arm;
  logic [23:0] c_addr; logic [7:0] c_got, c_exp;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic int bidx(input logic [23:0] a);
    int rg;
    case (a[23:20])
      4'h1: rg = 0;
      4'h4: rg = 1;
      4'h8: rg = 2;
      default: rg = -1;
    endcase
    if (rg < 0 || a[19:8] != 12'h0) return -1;
    return rg * MEM + int'(a[7:0]);
  endfunction

  task automatic step();
    bit rdy;
    int ix;
    @(negedge clk_i);
    cyc++;
    if (progress_o) prog_cnt++;
    if (done_o && !done_seen) begin
      done_seen = 1; done_allow = req_valid_o ? 1 : 0; rd_at_done = rd_resp;
    end
    if (prev_refused) begin
      if (!req_valid_o || req_addr_o != p_addr || req_write_o != p_wr ||
          req_uncached_o != p_uc || req_data_o != p_data) hold_err++;
    end
    case (ready_mode)
      0: rdy = 1'b0;
      1: rdy = (cyc % 5 != 2) && (cyc % 7 != 3);
      default: rdy = 1'b1;
    endcase
    req_ready_i = rdy;
    prev_refused = req_valid_o && !rdy;
    p_addr = req_addr_o; p_wr = req_write_o; p_uc = req_uncached_o; p_data = req_data_o;
    if (req_valid_o && !rdy) refusals++;
    if (req_valid_o && rdy) begin
      if (done_seen) after_done++;
      ix = bidx(req_addr_o);
      if (ix < 0 || req_addr_o[3:0] != 4'(ID)) form_err++;
      if (req_uncached_o != (req_addr_o[23:20] == 4'h8)) region_err++;
      if (ix >= 0) begin
        seen_rg[ix / MEM] = 1;
        if (busy[ix]) dup_err++;
        busy[ix] = 1;
        if (req_write_o) mem_m[ix] = req_data_o;
      end
      q_addr[tail % QN] = req_addr_o; q_wr[tail % QN] = req_write_o; q_due[tail % QN] = cyc + LAT;
      tail++;
      if (req_write_o) wr_acc++; else rd_acc++;
      if (tail - head > max_out) max_out = tail - head;
    end
    rsp_valid_i = 1'b0; rsp_write_i = 1'b0; rsp_data_i = '0;
    if (resp_en && head != tail && q_due[head % QN] <= cyc) begin
      ix = bidx(q_addr[head % QN]);
      rsp_valid_i = 1'b1;
      rsp_write_i = q_wr[head % QN];
      rsp_addr_i  = q_addr[head % QN];
      if (!q_wr[head % QN]) begin
        rsp_data_i = (ix >= 0) ? mem_m[ix] : 8'h00;
        if (corrupt_arm) begin
          c_addr = rsp_addr_i; c_exp = rsp_data_i; c_got = rsp_data_i ^ 8'h5a;
          rsp_data_i = c_got; corrupt_arm = 0;
        end
        rd_resp++;
      end
      if (ix >= 0) busy[ix] = 0;
      head++;
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; req_ready_i = 0; rsp_valid_i = 0; rsp_write_i = 0;
    rsp_addr_i = '0; rsp_data_i = '0;
    for (int i = 0; i < 3*MEM; i++) begin mem_m[i] = 8'h00; busy[i] = 0; end
    for (int i = 0; i < 3; i++) seen_rg[i] = 0;
    head = 0; tail = 0; form_err = 0; region_err = 0; dup_err = 0; hold_err = 0;
    refusals = 0; max_out = 0; rd_acc = 0; wr_acc = 0; rd_resp = 0; prog_cnt = 0;
    after_done = 0; done_allow = 0; rd_at_done = 0; done_seen = 0; prev_refused = 0;
    corrupt_arm = 0; cyc = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset_state();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    // R12
    chk(req_valid_o == 0, "R12", "req_valid_o in reset", req_valid_o, 0);
    chk(mismatch_o == 0, "R12", "mismatch_o in reset", mismatch_o, 0);
    chk(deadlock_o == 0, "R12", "deadlock_o in reset", deadlock_o, 0);
    chk(progress_o == 0, "R12", "progress_o in reset", progress_o, 0);
    chk(done_o == 0, "R12", "done_o in reset", done_o, 0);
  endtask

  task automatic t_traffic();
    int post;
    do_reset();
    ready_mode = 1; resp_en = 1; post = 0;
    while (post < 80 && cyc < 6000) begin
      step();
      if (done_seen) post++;
      if (done_seen && post == 1)
        chk(deadlock_o == 0, "R8", "no deadlock while responses flow", deadlock_o, 0);
    end
    chk(rd_acc > 0 && wr_acc > 0, "R1", "reads and writes both issued", {rd_acc[15:0], wr_acc[15:0]}, 1);
    chk(form_err == 0, "R2", "address form errors", form_err, 0);
    chk(region_err == 0 && seen_rg[0] && seen_rg[1] && seen_rg[2], "R3", "region/flag use",
        {region_err[28:0], seen_rg[2], seen_rg[1], seen_rg[0]}, 7);
    chk(dup_err == 0, "R4", "duplicate in-flight address", dup_err, 0);
    chk(hold_err == 0 && refusals > 0, "R5", "refused request held", hold_err, 0);
    chk(mismatch_o == 0, "R6", "mismatch with correct memory", mismatch_o, 0);
    chk(done_seen && rd_at_done == MAXL, "R10", "reads at done rise", rd_at_done, MAXL);
    chk(after_done <= done_allow, "R10", "requests after done", after_done, done_allow);
    chk(done_o == 1, "R10", "done stays set", done_o, 1);
    chk(prog_cnt == rd_resp / PROG, "R9", "progress pulses", prog_cnt, rd_resp / PROG);
    chk(max_out <= SLOTS, "R11", "outstanding bound", max_out, SLOTS);
  endtask

  task automatic t_stall_deadlock();
    do_reset();
    ready_mode = 2; resp_en = 0;
    repeat (150) step();
    // R11: table full stops generation
    chk(tail - head == SLOTS, "R11", "requests in flight with no responses", tail - head, SLOTS);
    chk(req_valid_o == 0, "R11", "no request while table full", req_valid_o, 0);
    while (cyc < DL - 5) step();
    chk(deadlock_o == 0, "R8", "deadlock before limit", deadlock_o, 0);
    repeat (10) step();
    chk(deadlock_o == 1, "R8", "deadlock after limit", deadlock_o, 1);
    repeat (5) step();
    chk(deadlock_o == 1, "R8", "deadlock sticky", deadlock_o, 1);
  endtask

  task automatic t_corrupt();
    logic [23:0] a0; logic [7:0] g0, e0;
    do_reset();
    ready_mode = 2; resp_en = 1;
    repeat (40) step();
    chk(mismatch_o == 0, "R6", "clean before corruption", mismatch_o, 0);
    corrupt_arm = 1;
    repeat (60) step();
    chk(corrupt_arm == 0, "R7", "corrupted read delivered", corrupt_arm, 0);
    chk(mismatch_o == 1, "R7", "mismatch raised", mismatch_o, 1);
    chk(mis_addr_o == c_addr, "R7", "mismatch address", mis_addr_o, c_addr);
    chk(mis_got_o == c_got, "R7", "mismatch returned byte", mis_got_o, c_got);
    chk(mis_exp_o == c_exp, "R7", "mismatch expected byte", mis_exp_o, c_exp);
    a0 = c_addr; g0 = c_got; e0 = c_exp;
    corrupt_arm = 1;
    repeat (60) step();
    chk(mismatch_o == 1 && mis_addr_o == a0 && mis_got_o == g0 && mis_exp_o == e0,
        "R7", "first mismatch kept", {mis_addr_o, mis_got_o}, {a0, g0});
  endtask

  initial begin
    #(4 * WD_CYC);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual %0d expected %0d", WD_CYC, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    req_ready_i = 0; rsp_valid_i = 0; rsp_write_i = 0; rsp_addr_i = '0; rsp_data_i = '0;
    ready_mode = 0; resp_en = 0;
    t_reset_state();
    t_traffic();
    t_stall_deadlock();
    t_corrupt();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule